// File: doc/BRIEF.md
# Sequencer Run Control

This block decides when a small microprogram sequencer begins and ends execution. It takes two request lines, start and stop, which may change at any time relative to the clock. Each passes through its own synchroniser, and only a rising edge counts as a request. A start request produces a load-begin command that sets the program counter to the first program address. A stop request produces a load-end command that parks the program counter on the end address.

Two more sources raise load-end without any user request. The first is a one-shot detector that fires when the program counter runs past the end address. The second is a self-timed power-up hold that is released a fixed number of clocks after reset. Together they make sure the program counter leaves its all-ones power-up value and settles on the end address before any program starts. Every load command lasts exactly two clocks. A one-clock flag marks the first cycle of each load-begin, so the sequencer can hold off increments and jumps while it starts up. A registered status bit reports whether the program counter sits on the end address.

Top module: `seq_run_ctrl`

## Requirements
- R1: A request line passes through three flops. A low-to-high change on `start_i` that is first sampled at clock edge k makes `load_begin_o` high after edge k+2. Keeping the line high does not start another request.
- R2: Each detected start edge drives `load_begin_o` high for exactly two consecutive clocks, the detection cycle and the one after it.
- R3: `begin_hold_o` is high for one clock only, in the first cycle of each load-begin burst, and is never high while `load_begin_o` is low.
- R4: A low-to-high change on `stop_i` that is first sampled at edge k drives `load_end_o` high after edges k+2 and k+3.
- R5: After reset is released, an internal 6-bit timer counts while the power-up hold is active. The hold is active while timer bits [5:4] differ from binary 10, so it drops after edge 33. When the hold drops, `load_end_o` is high after edges 34 and 35 and the hold never returns.
- R6: When `pc_i` exceeds `end_addr_i` at an edge and the overrun flag is low, the flag is set for one clock. `load_end_o` is high after the following two edges.
- R7: `running_o` is 0 after an edge at which `pc_i` equals `end_addr_i`, and 1 after an edge at which they differ.
- R8: While `rst_ni` is low, all four outputs are 0.
- R9: With the program counter powering up at all ones and no start request, power-up leaves the counter on the end address and `running_o` at 0 well before the hold drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, asynchronous |
| stop_i | input | 1 | Stop request, asynchronous |
| pc_i | input | PC_W | Current program counter |
| end_addr_i | input | PC_W | End address of the program |
| load_begin_o | output | 1 | Load program counter with first address |
| load_end_o | output | 1 | Load program counter with end address |
| begin_hold_o | output | 1 | First cycle of a load-begin burst |
| running_o | output | 1 | 1 when the program counter is off the end address |

## Verification
The assertions check, on every clock, the properties that hold at all times: a detected edge lasts one clock, loads are stretched to a second clock, the hold flag sits inside load-begin, the overrun flag is a one-shot, the power-up hold never comes back once released, and the status follows the compared addresses. Only the bench scenarios can show the absolute latencies. These are the three-flop delay from a request to its load, the exact edge at which the power-up hold releases, and the closed loop with a modelled program counter that starts at all ones and ends parked on the end address. A held start line must also produce only one burst, and random request and address patterns must match a cycle model on all outputs.

// File: rtl/seq_run_pkg.sv
package seq_run_pkg;
  typedef logic [1:0] tap_t;
  // timer top bits at which the power-up hold releases
  localparam tap_t RELEASE_TAP = 2'b10;

  typedef struct packed {
    logic pulse;
    logic first;
  } ld_cmd_t;
endpackage

// File: rtl/seq_edge_sync.sv
module seq_edge_sync #(
  parameter int STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign chain_d = {chain_q[STAGES-2:0], async_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rise_o = chain_q[STAGES-2] & ~chain_q[STAGES-1];

  a_r1_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/seq_pulse_stretch.sv
module seq_pulse_stretch
  import seq_run_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    trig_i,
  output ld_cmd_t cmd_o
);
  logic first_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      first_q <= trig_i;
      pulse_q <= trig_i | first_q;
    end
  end

  assign cmd_o.pulse = pulse_q;
  assign cmd_o.first = first_q;

  a_r2_two_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_q) |=> pulse_q);
  a_r3_first_inside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |-> pulse_q);
endmodule

// File: rtl/seq_pwrup_timer.sv
module seq_pwrup_timer
  import seq_run_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic active_o,
  output logic release_o
);
  localparam int TAP_LO = CNT_W - 2;

  logic [CNT_W-1:0] cnt_q;
  logic             active_q, active_d1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      active_q    <= 1'b1;
      active_d1_q <= 1'b1;
    end else begin
      if (active_q) cnt_q <= cnt_q + 1'b1;
      active_q    <= (cnt_q[CNT_W-1:TAP_LO] != RELEASE_TAP);
      active_d1_q <= active_q;
    end
  end

  assign active_o  = active_q;
  assign release_o = ~active_q & active_d1_q;

  a_r5_stays_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |=> !active_q);
  a_r5_release_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |=> !release_o);
endmodule

// File: rtl/seq_run_ctrl.sv
module seq_run_ctrl
  import seq_run_pkg::*;
#(
  parameter int PC_W        = 8,
  parameter int PWRUP_W     = 6,
  parameter int SYNC_STAGES = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] end_addr_i,
  output logic            load_begin_o,
  output logic            load_end_o,
  output logic            begin_hold_o,
  output logic            running_o
);
  logic    start_rise, stop_rise;
  logic    pwr_active, pwr_release;
  logic    over_q, running_q;
  logic    end_trig;
  ld_cmd_t begin_cmd, end_cmd;

  seq_edge_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(start_i), .rise_o(start_rise));

  seq_edge_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(stop_i), .rise_o(stop_rise));

  seq_pwrup_timer #(.CNT_W(PWRUP_W)) u_pwrup (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_o(pwr_active), .release_o(pwr_release));

  // overrun one-shot: re-arms every other clock while the PC stays past the end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      over_q    <= 1'b0;
      running_q <= 1'b0;
    end else begin
      over_q    <= (pc_i > end_addr_i) && !over_q;
      running_q <= (pc_i != end_addr_i);
    end
  end

  assign end_trig = over_q | pwr_release | stop_rise;

  seq_pulse_stretch u_begin_str (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(start_rise), .cmd_o(begin_cmd));

  seq_pulse_stretch u_end_str (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(end_trig), .cmd_o(end_cmd));

  assign load_begin_o = begin_cmd.pulse;
  assign begin_hold_o = begin_cmd.first;
  assign load_end_o   = end_cmd.pulse;
  assign running_o    = running_q;

  a_r6_over_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_q |=> !over_q);
  a_r6_over_to_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_q |=> load_end_o);
  a_r4_stop_to_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_rise |=> load_end_o);
  a_r5_release_to_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_active) |=> load_end_o);
  a_r7_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_i != end_addr_i) |=> running_o);
  a_r7_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_i == end_addr_i) |=> !running_o);
  a_r8_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !(load_begin_o || load_end_o || begin_hold_o || running_o));
endmodule

// File: tb/seq_run_ctrl_tb_top.sv
module seq_run_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 8;
  localparam logic [PC_W-1:0] END_ADDR = 8'd40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_r = 1'b0, stop_r = 1'b0;
  logic [PC_W-1:0] pc_q;
  logic ovr_en = 1'b0;
  logic [PC_W-1:0] ovr_val = '0;
  logic lb, le, bh, run;
  logic cmp_en = 1'b0;
  logic done = 1'b0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_run_ctrl #(.PC_W(PC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_r), .stop_i(stop_r),
    .pc_i(pc_q), .end_addr_i(END_ADDR),
    .load_begin_o(lb), .load_end_o(le), .begin_hold_o(bh), .running_o(run));

  // bench program counter: powers up all ones, obeys loads, counts up to the end
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc_q <= '1;
    else if (ovr_en)     pc_q <= ovr_val;
    else if (lb)         pc_q <= '0;
    else if (le)         pc_q <= END_ADDR;
    else if (pc_q < END_ADDR) pc_q <= pc_q + 1'b1;
  end

  // cycle model built from the requirements
  logic [2:0] m_ss, m_ts;
  logic [5:0] m_cnt;
  logic m_pwr, m_pwr_d, m_gt, m_bfirst, m_lb, m_efirst, m_le, m_run;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ss <= '0; m_ts <= '0; m_cnt <= '0; m_pwr <= 1'b1; m_pwr_d <= 1'b1;
      m_gt <= 1'b0; m_bfirst <= 1'b0; m_lb <= 1'b0; m_efirst <= 1'b0;
      m_le <= 1'b0; m_run <= 1'b0;
    end else begin
      automatic logic b_edge = m_ss[1] & ~m_ss[2];
      automatic logic e_ev = m_gt | (~m_pwr & m_pwr_d) | (m_ts[1] & ~m_ts[2]);
      m_ss <= {m_ss[1:0], start_r};
      m_ts <= {m_ts[1:0], stop_r};
      if (m_pwr) m_cnt <= m_cnt + 6'd1;
      m_pwr <= (m_cnt < 6'd32) || (m_cnt >= 6'd48);
      m_pwr_d <= m_pwr;
      m_gt <= (pc_q > END_ADDR) && !m_gt;
      m_bfirst <= b_edge;
      m_lb <= b_edge | m_bfirst;
      m_efirst <= e_ev;
      m_le <= e_ev | m_efirst;
      m_run <= (pc_q != END_ADDR);
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n && !done) begin
      chk("R2 load_begin model", lb, m_lb);
      chk("R3 begin_hold model", bh, m_bfirst);
      chk("R4 load_end model", le, m_le);
      chk("R7 running model", run, m_run);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int lb_cnt, bh_cnt;
    void'($urandom(32'h5eed_1234));
    step(3);
    // R8: reset state
    chk("R8 load_begin in reset", lb, 1'b0);
    chk("R8 load_end in reset", le, 1'b0);
    chk("R8 begin_hold in reset", bh, 1'b0);
    chk("R8 running in reset", run, 1'b0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    step(2);
    chk("R6 overrun of power-up PC", le, 1'b1);
    step(18);                                   // after edge 20
    chk("R5 quiet before release", le, 1'b0);
    step(10);                                   // after edge 30
    chk("R9 PC parked at end", (pc_q == END_ADDR), 1'b1);
    chk("R9 stopped before start", run, 1'b0);
    step(3);                                    // edge 33
    chk("R5 no end load at edge 33", le, 1'b0);
    step(1);
    chk("R5 end load at edge 34", le, 1'b1);
    step(1);
    chk("R5 end load at edge 35", le, 1'b1);
    step(1);
    chk("R5 end load done at edge 36", le, 1'b0);

    // R1 latency and R2/R3 shape
    start_r = 1'b1;
    step(2);
    chk("R1 no begin after two edges", lb, 1'b0);
    step(1);
    chk("R1 begin after third edge", lb, 1'b1);
    chk("R3 hold in first cycle", bh, 1'b1);
    step(1);
    chk("R2 begin second cycle", lb, 1'b1);
    chk("R3 hold only one cycle", bh, 1'b0);
    step(1);
    chk("R2 begin ends after two", lb, 1'b0);
    // R1 held start: no new burst
    lb_cnt = 0; bh_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (lb) lb_cnt++;
      if (bh) bh_cnt++;
    end
    chk("R1 held start no retrigger", (lb_cnt == 0), 1'b1);
    start_r = 1'b0;
    step(50);
    chk("R7 program ran to end", run, 1'b0);

    // R4 stop latency
    stop_r = 1'b1;
    step(2);
    chk("R4 no end load after two edges", le, 1'b0);
    step(1);
    chk("R4 end load after third edge", le, 1'b1);
    step(1);
    chk("R4 end load second cycle", le, 1'b1);
    step(1);
    chk("R4 end load ends", le, 1'b0);
    stop_r = 1'b0;
    step(5);

    // R6 overrun from a jump past the end
    ovr_en = 1'b1; ovr_val = END_ADDR + 8'd3;
    step(1);                                    // edge a: pc past end
    ovr_en = 1'b0;
    step(1);
    chk("R6 no end load before flag", le, 1'b0);
    step(1);
    chk("R6 end load after flag", le, 1'b1);
    step(8);
    chk("R6 PC back on end", (pc_q == END_ADDR), 1'b1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0)  start_r = ~start_r;
      if ($urandom_range(11) == 0) stop_r = ~stop_r;
      ovr_en = ($urandom_range(15) == 0);
      ovr_val = PC_W'($urandom_range(255));
      step(1);
    end
    ovr_en = 1'b0;
    step(5);
    finish_run();
  end
endmodule